// File: doc/BRIEF.md
# Sticky Fault and Warning Status Register

This block gathers event indications from a battery charger controller into one status register. Each bit of the register belongs to one of two classes, fault or warning, chosen by a parameter mask. A rising edge on an event input sets its bit, and the bit stays set until the host reads the register. The read clears every bit, whatever its class.

An active-low fault indicator is pulled low while any fault-class bit is set. Warning-class bits are recorded but never move the indicator. The indicator returns high only when no fault-class bit remains set.

The host reaches the register through a serial register-access front end that is not part of this block. That front end may step through sub-addresses automatically, so a status read can arrive as one byte of a longer burst. Here the front end appears only as a single-cycle read strobe. The read data is the register contents captured on the strobe cycle, taken before the clear.

Top module: `fault_status_reg`

## Requirements
- R1: A 0-to-1 transition on event input bit i sets status bit i at the next clock edge.
- R2: An event input held high sets its bit only once; after a read clears the bit, it stays clear while the input stays high.
- R3: A set status bit stays set after its event input falls, for any number of cycles without a read.
- R4: A read strobe clears every status bit, fault-class and warning-class alike, at the clock edge on which it is sampled.
- R5: On a read strobe, `rd_data_o` is loaded at that edge with the status value from before the clear, and it holds that value until the next read strobe; two strobes in a row return the old value and then the cleared value.
- R6: An event edge on the same edge as a read strobe is not lost: the read returns the old value and the new bit is set afterwards.
- R7: `fault_n_o` is 0 while any status bit i with `FAULT_MASK[i]`=1 is set. The default mask is 8'h0F, so bits 0 to 3 are faults and bits 4 to 7 are warnings.
- R8: Status bits with `FAULT_MASK[i]`=0 (warnings) are recorded, but they never drive `fault_n_o` low.
- R9: `fault_n_o` returns to 1 only when no fault-class bit is set. It stays 0 across a read that coincides with a new fault event.
- R10: A synchronous active-high reset clears every status bit and `rd_data_o`, and sets `fault_n_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_BITS | Event inputs, synchronous to clk_i, edge-detected |
| rd_i | input | 1 | One-cycle status read strobe from the register-access front end |
| rd_data_o | output | NUM_BITS | Status captured on the last read, taken before the clear |
| fault_n_o | output | 1 | Active-low fault indicator |

## Verification
The assertions assume that `evt_i` and `rd_i` are synchronous to `clk_i`. They also assume that reset is held for at least one edge at time zero, so the edge-detector history starts from a known value. The bench changes every input only on the falling clock edge, and it asserts reset from time zero for several cycles. It raises event inputs only after reset has been released, so no rising edge is hidden inside a reset. The bench also produces a read strobe on the same edge as a new event, and it issues strobes on consecutive cycles, as a burst read would.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic {
    CLS_WARN  = 1'b0,
    CLS_FAULT = 1'b1
  } evt_class_e;

  localparam int unsigned FSR_MAX_W = 32;

  // Class of bit idx under a class mask (1 = fault)
  function automatic evt_class_e class_of(input logic [FSR_MAX_W-1:0] mask, input int idx);
    return mask[idx] ? CLS_FAULT : CLS_WARN;
  endfunction

  // Rising edge of a single level against its previous value
  function automatic logic rise_bit(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // Next value of one sticky cell: clear on read, but a same-cycle set wins
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/fsr_edge_det.sv
module fsr_edge_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  import fsr_pkg::*;

  logic [W-1:0] lvl_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) lvl_q <= '0;
    else       lvl_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_rise
    assign rise_o[g] = rise_bit(lvl_i[g], lvl_q[g]);
  end
endmodule

// File: rtl/fsr_sticky_bank.sv
module fsr_sticky_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  import fsr_pkg::*;

  for (genvar g = 0; g < W; g++) begin : g_cell
    logic cell_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) cell_q <= 1'b0;
      else       cell_q <= sticky_next(cell_q, set_i[g], clr_i);
    end
    assign stat_o[g] = cell_q;
  end
endmodule

// File: rtl/fsr_read_port.sv
module fsr_read_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         rd_i,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)     data_q <= '0;
    else if (rd_i) data_q <= stat_i;
  end

  assign data_o = data_q;
endmodule

// File: rtl/fsr_fault_drv.sv
module fsr_fault_drv #(
  parameter int unsigned   W    = 8,
  parameter logic [W-1:0]  MASK = 8'h0F
) (
  input  logic [W-1:0] stat_i,
  output logic         fault_n_o
);
  import fsr_pkg::*;

  localparam logic [FSR_MAX_W-1:0] MASK_EXT = FSR_MAX_W'(MASK);

  logic [W-1:0] fault_bits;

  for (genvar g = 0; g < W; g++) begin : g_cls
    if (class_of(MASK_EXT, g) == CLS_FAULT) begin : g_fault
      assign fault_bits[g] = stat_i[g];
    end else begin : g_warn
      assign fault_bits[g] = 1'b0;
    end
  end

  assign fault_n_o = ~(|fault_bits);
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg #(
  parameter int unsigned              NUM_BITS   = 8,
  parameter logic [NUM_BITS-1:0]      FAULT_MASK = 8'h0F
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_BITS-1:0] evt_i,
  input  logic                rd_i,
  output logic [NUM_BITS-1:0] rd_data_o,
  output logic                fault_n_o
);
  // Named internal events, brought out for the checker
  logic [NUM_BITS-1:0] rise_w;
  logic [NUM_BITS-1:0] stat_w;

  fsr_edge_det #(.W(NUM_BITS)) edge_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .lvl_i (evt_i),
    .rise_o(rise_w)
  );

  fsr_sticky_bank #(.W(NUM_BITS)) bank_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .set_i (rise_w),
    .clr_i (rd_i),
    .stat_o(stat_w)
  );

  fsr_read_port #(.W(NUM_BITS)) rdp_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .rd_i  (rd_i),
    .stat_i(stat_w),
    .data_o(rd_data_o)
  );

  fsr_fault_drv #(.W(NUM_BITS), .MASK(FAULT_MASK)) drv_i (
    .stat_i   (stat_w),
    .fault_n_o(fault_n_o)
  );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] MASK = 8'h0F
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         rd_i,
  input logic [W-1:0] rise_w,
  input logic [W-1:0] stat_w,
  input logic [W-1:0] rd_data_o,
  input logic         fault_n_o
);
  AST_SET_ON_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
    (|rise_w) |=> ((stat_w & $past(rise_w)) == $past(rise_w))); // R1

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_i |=> ((stat_w & $past(stat_w)) == $past(stat_w))); // R3

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((stat_w & ~$past(stat_w) & ~$past(rise_w)) == '0)); // R2

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_i |=> ((stat_w & ~$past(rise_w)) == '0)); // R4

  AST_READ_DATA_OLD: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_i |=> (rd_data_o == $past(stat_w))); // R5

  AST_READ_DATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_i |=> $stable(rd_data_o)); // R5

  AST_COLLIDE_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_i && (|rise_w)) |=> (stat_w == $past(rise_w))); // R6

  AST_FAULT_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    ((stat_w & MASK) != '0) |-> !fault_n_o); // R7

  AST_WARN_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
    ((stat_w & MASK) == '0) |-> fault_n_o); // R8

  AST_RELEASE_CLEAN: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(fault_n_o) |-> ((stat_w & MASK) == '0)); // R9

  AST_RESET_STATE: assert property (@(posedge clk_i)
    rst_i |=> (stat_w == '0 && rd_data_o == '0 && fault_n_o)); // R10
endmodule

bind fault_status_reg fsr_checker #(.W(NUM_BITS), .MASK(FAULT_MASK)) chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .rd_i     (rd_i),
  .rise_w   (rise_w),
  .stat_w   (stat_w),
  .rd_data_o(rd_data_o),
  .fault_n_o(fault_n_o)
);

// File: tb/fault_status_reg_tb_top.sv
module fault_status_reg_tb_top;
  localparam int unsigned NB = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] evt = '0;
  logic          rd  = 1'b0;
  logic [NB-1:0] rd_data;
  logic          fault_n;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  fault_status_reg #(.NUM_BITS(NB), .FAULT_MASK(8'h0F)) dut_i (
    .clk_i    (clk),
    .rst_i    (rst),
    .evt_i    (evt),
    .rd_i     (rd),
    .rd_data_o(rd_data),
    .fault_n_o(fault_n)
  );

  // Bench view of the class mask: bits 0..3 are faults
  function automatic logic exp_pin(input logic [NB-1:0] st);
    return ((st & 8'h0F) == 8'h00);
  endfunction

  task automatic check(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [NB-1:0] v);
    evt = v;
    tick(1);
    evt = '0;
  endtask

  task automatic do_read(output logic [NB-1:0] d);
    rd = 1'b1;
    tick(1);
    rd = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset_state();
    check("R10 fault pin in reset", {7'd0, fault_n}, 8'h01);
    check("R10 read data in reset", rd_data, 8'h00);
  endtask

  task automatic t_fault_bit();
    logic [NB-1:0] d;
    pulse(8'h01);
    check("R7 fault pin low", {7'd0, fault_n}, {7'd0, exp_pin(8'h01)});
    do_read(d);
    check("R1 fault bit set", d, 8'h01);
    check("R9 pin released", {7'd0, fault_n}, 8'h01);
  endtask

  task automatic t_warning_bit();
    logic [NB-1:0] d;
    pulse(8'h10);
    check("R8 warning leaves pin high", {7'd0, fault_n}, 8'h01);
    do_read(d);
    check("R1 warning bit set", d, 8'h10);
    do_read(d);
    check("R4 warning cleared by read", d, 8'h00);
  endtask

  task automatic t_sticky();
    logic [NB-1:0] d;
    pulse(8'h04);
    tick(6);
    check("R3 pin still low", {7'd0, fault_n}, 8'h00);
    do_read(d);
    check("R3 bit held", d, 8'h04);
  endtask

  task automatic t_held_level();
    logic [NB-1:0] d;
    evt = 8'h22;
    tick(1);
    do_read(d);
    check("R2 first read of held level", d, 8'h22);
    check("R4 fault cleared though level high", {7'd0, fault_n}, 8'h01);
    tick(3);
    do_read(d);
    check("R2 no re-set while held", d, 8'h00);
    evt = '0;
    tick(1);
  endtask

  task automatic t_collision();
    logic [NB-1:0] d;
    pulse(8'h02);
    rd = 1'b1;
    evt = 8'h48;
    tick(1);
    rd = 1'b0;
    evt = '0;
    check("R6 read returns old value", rd_data, 8'h02);
    check("R9 pin stays low on coincident fault", {7'd0, fault_n}, 8'h00);
    do_read(d);
    check("R6 coincident event kept", d, 8'h48);
    check("R9 pin released after clear", {7'd0, fault_n}, 8'h01);
  endtask

  task automatic t_burst();
    logic [NB-1:0] d;
    pulse(8'h30);
    pulse(8'h01);
    rd = 1'b1;
    tick(1);
    check("R5 burst first byte", rd_data, 8'h31);
    tick(1);
    rd = 1'b0;
    check("R5 burst second byte", rd_data, 8'h00);
    pulse(8'h11);
    do_read(d);
    check("R5 read of mixed bits", d, 8'h11);
    pulse(8'h02);
    tick(2);
    check("R5 data held until next read", rd_data, 8'h11);
    do_read(d);
    check("R4 fault bit cleared next read", d, 8'h02);
  endtask

  task automatic t_mid_reset();
    logic [NB-1:0] d;
    pulse(8'h8F);
    check("R7 several faults low", {7'd0, fault_n}, 8'h00);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    check("R10 pin after reset", {7'd0, fault_n}, 8'h01);
    check("R10 data after reset", rd_data, 8'h00);
    do_read(d);
    check("R10 status cleared", d, 8'h00);
  endtask

  initial begin
    tick(4);
    t_reset_state();
    rst = 1'b0;
    tick(1);
    t_fault_bit();
    t_warning_bit();
    t_sticky();
    t_held_level();
    t_collision();
    t_burst();
    t_mid_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule